// File: doc/BRIEF.md
# Programmable Serial Pattern Detector

The block samples a one-bit serial stream on every rising clock edge and raises a flag when the four most recent bits equal a 4-bit target. The target comes from a parallel input and may change at run time. The detector reports every occurrence, including occurrences that overlap, so a single stream bit can complete one window and also belong to the next.

The output is registered, which makes the block a Moore machine. The flag depends only on stored state. It does not depend on the serial bit or the target currently at the inputs. The state consists of a shift history of the received bits and a saturating count of the bits taken since reset. The count stops a freshly cleared history from matching an all-zero target.

Top module: `sdet_top`

## Requirements
- R1: `det_o` is high for exactly the one cycle after the rising edge that samples the fourth bit of a matching window. At every other time it is low.
- R2: Bit order within a window: the oldest of the four bits is compared with `pat_i[3]` and the newest with `pat_i[0]`. A reversed window does not match.
- R3: No detection is reported until at least four bits have been sampled since the last reset.
- R4: Reset is synchronous. A rising edge with `rst_i` high clears the history and the bit count, and leaves `det_o` low for the following cycle.
- R5: Overlapping matches are all reported. With target 1010, the stream 1,0,1,0,1,0 gives detections after the fourth and the sixth bit.
- R6: Detections may occur on consecutive cycles. With target 1111 and a steady run of ones, `det_o` stays high on every cycle once four ones have arrived.
- R7: Each window is compared against the value of `pat_i` present on the edge that samples its completing bit. A change of `pat_i` affects only windows that complete after the change.
- R8: Between clock edges, `det_o` does not change in response to `sd_i` or `pat_i`.
- R9: After reset with target 0000, no detection occurs until four zero bits have actually been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every action happens on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| sd_i | input | 1 | Serial data bit, sampled each rising edge |
| pat_i | input | 4 | Target sequence; bit 3 is the oldest bit of a window |
| det_o | output | 1 | Registered detect flag |

## Verification
Two things can happen on the same edge. The sampled bit completes one window while also starting or continuing the next window, and the target can change on that same edge. The bench provokes overlap with target 1010 over an alternating stream, and provokes back-to-back detection with target 1111 over a run of ones. It also changes `pat_i` on the exact edge that completes a window, and judges the result against the new target alone. A separate check alters `sd_i` and `pat_i` in mid-cycle while the flag is high, and confirms that the flag holds until the next edge.

// File: rtl/sdet_pkg.sv
package sdet_pkg;

  // Default window length of the detector.
  localparam int SDET_WIN_DEF = 4;

  // Saturating increment used by the bit counter.
  function automatic int sat_step(input int cur, input int lim);
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

endpackage

// File: rtl/sdet_history.sv
module sdet_history
  import sdet_pkg::*;
#(
  parameter int WIN = SDET_WIN_DEF,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sd_i,
  output logic [WIN-1:0]   hist_q,
  output logic [WIN-1:0]   hist_nxt,
  output logic [CNT_W-1:0] fill_q,
  output logic             full_nxt
);

  logic [CNT_W-1:0] fill_nxt;

  // The newest bit enters at position 0; older bits move toward the top.
  always_comb begin
    hist_nxt = {hist_q[WIN-2:0], sd_i};
    fill_nxt = CNT_W'(sat_step(int'(fill_q), WIN));
    full_nxt = (fill_nxt == CNT_W'(WIN));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_nxt;
      fill_q <= fill_nxt;
    end
  end

  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (hist_q[0] == $past(sd_i)));  // R2
  AST_FILL_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (fill_q < CNT_W'(WIN)) |=> (fill_q == $past(fill_q) + 1'b1));  // R3
  AST_FILL_SAT: assert property (@(posedge clk_i) disable iff (rst_i)
    fill_q <= CNT_W'(WIN));  // R3

endmodule

// File: rtl/sdet_match.sv
module sdet_match
  import sdet_pkg::*;
#(
  parameter int WIN = SDET_WIN_DEF
) (
  input  logic [WIN-1:0] win_i,
  input  logic [WIN-1:0] pat_i,
  input  logic           full_i,
  output logic           hit_o
);

  logic [WIN-1:0] bit_eq;

  // One equality cell per window position; the top bit is the oldest.
  for (genvar g = 0; g < WIN; g++) begin : g_cmp
    assign bit_eq[g] = ~(win_i[g] ^ pat_i[g]);
  end

  assign hit_o = full_i & (&bit_eq);

endmodule

// File: rtl/sdet_flag.sv
module sdet_flag (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hit_i,
  output logic det_q
);

  always_ff @(posedge clk_i) begin
    if (rst_i) det_q <= 1'b0;
    else       det_q <= hit_i;
  end

endmodule

// File: rtl/sdet_top.sv
module sdet_top
  import sdet_pkg::*;
#(
  parameter int WIN = SDET_WIN_DEF,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           sd_i,
  input  logic [WIN-1:0] pat_i,
  output logic           det_o
);

  // Internal events are brought out as named wires for the checks below.
  logic [WIN-1:0]   hist_q;
  logic [WIN-1:0]   hist_nxt;
  logic [CNT_W-1:0] fill_q;
  logic             full_nxt;
  logic             win_hit;

  sdet_history #(.WIN(WIN)) u_hist (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .sd_i     (sd_i),
    .hist_q   (hist_q),
    .hist_nxt (hist_nxt),
    .fill_q   (fill_q),
    .full_nxt (full_nxt)
  );

  sdet_match #(.WIN(WIN)) u_match (
    .win_i  (hist_nxt),
    .pat_i  (pat_i),
    .full_i (full_nxt),
    .hit_o  (win_hit)
  );

  sdet_flag u_flag (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .hit_i (win_hit),
    .det_q (det_o)
  );

  AST_DET_WINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
    det_o |-> (hist_q == $past(pat_i)));  // R1
  AST_NO_EARLY: assert property (@(posedge clk_i) disable iff (rst_i)
    (fill_q < CNT_W'(WIN - 1)) |=> !det_o);  // R3
  AST_DET_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
    det_o |-> (fill_q == CNT_W'(WIN)));  // R9

endmodule

// File: tb/sdet_top_tb_top.sv
`timescale 1ns/1ps
module sdet_top_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       sd;
  logic [3:0] pat;
  logic       det;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sdet_top dut_i (
    .clk_i (clk),
    .rst_i (rst),
    .sd_i  (sd),
    .pat_i (pat),
    .det_o (det)
  );

  // Entry: {rst, sd, pat[3:0], expected det after the edge}
  localparam int NV = 26;
  localparam logic [6:0] VEC [0:NV-1] = '{
    7'b1_1_1010_0, 7'b0_1_1010_0, 7'b0_0_1010_0, 7'b0_1_1010_0,
    7'b0_0_1010_1, 7'b0_1_1010_0, 7'b0_0_1010_1, 7'b0_1_1010_0,
    7'b0_0_0101_0, 7'b0_1_0101_1, 7'b0_1_1111_0, 7'b0_1_1111_0,
    7'b0_1_1111_1, 7'b0_1_1111_1, 7'b0_1_1111_1, 7'b0_0_1110_1,
    7'b1_0_0000_0, 7'b0_0_0000_0, 7'b0_0_0000_0, 7'b0_0_0000_0,
    7'b0_0_0000_1, 7'b0_0_0001_0, 7'b0_1_0001_1, 7'b0_0_0010_1,
    7'b0_0_0100_1, 7'b0_0_0001_0
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 16:               return "R4";
      1, 2, 3, 17, 18, 19: return "R3";
      6:                   return "R5";
      8, 9, 15:            return "R7";
      12, 13, 14:          return "R6";
      20:                  return "R9";
      21, 22, 23, 24, 25:  return "R2";
      default:             return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: det=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic s, input logic [3:0] p);
    @(negedge clk);
    rst = r; sd = s; pat = p;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1; sd = 1'b0; pat = 4'b0000;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4:1]);
      check(tag_of(i), det, VEC[i][0]);
    end

    // R8: flag high, then disturb inputs in mid-cycle; flag must hold.
    step(1'b1, 1'b0, 4'b1111);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 4'b1111);
    check("R1", det, 1'b1);
    sd = 1'b0; pat = 4'b0000;
    #1;
    check("R8", det, 1'b1);
    // R7: window 1110 against the new target 0000 gives no detection.
    @(posedge clk); #1;
    check("R7", det, 1'b0);

    // R4: reset in the middle of a run of ones clears the history.
    step(1'b1, 1'b1, 4'b1111);
    check("R4", det, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b1, 4'b1111);
      check("R3", det, 1'b0);
    end
    step(1'b0, 1'b1, 4'b1111);
    check("R6", det, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, got=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule